// File: doc/BRIEF.md
# Dead-Time Waveform Generator Pair

This block shapes the drive for one half-bridge of a motor inverter. It takes two PWM levels from a pair of compare channels (a low-side level `pwm_lo` and a high-side level `pwm_hi`) and the output of an external pulse generator (`pulse_in`). From these it produces a complementary pair of gate-drive outputs. A 16-bit down counter is loaded from `reload_val` and stepped by a programmable prescaler. Depending on the selected mode, the counter either inserts dead time between the two outputs or limits how long chopper pulses are allowed through.

There are five waveform modes: pass-through, pulse superimposition, timer-gated pulses, dead time derived from the PWM level and dead time derived from the pulse signal. In the two dead-time modes the output polarity can be inverted. The block also drives a gate-enable signal that starts the pulse generator. When the selected mode does not need the counter for waveforms, the counter runs as a periodic reload timer and raises a one-cycle interrupt.

All outputs are registered, so each reacts one clock after its inputs. The ratio is 2^`div_sel` clocks per timer step, so a dead interval lasts `reload_val` × 2^`div_sel` clocks.

Top module: `dtwg_pair`

## Requirements
- R1: Mode code 0 (and the unused codes 5 to 7) is pass-through: one clock after the inputs, `drv_hi` equals `pwm_hi`, `drv_lo` equals `pwm_lo`, and `gate_en` is 0.
- R2: Mode code 1 superimposes the pulse: one clock later, `drv_hi` = `pwm_hi` AND `pulse_in`, `drv_lo` = `pwm_lo` AND `pulse_in`, and `gate_en` = `pwm_lo` OR `pwm_hi`.
- R3: In mode code 2, a rising edge on either PWM input loads the counter. For the next `reload_val`×2^`div_sel` clocks, each output equals its PWM input AND `pulse_in`, and `gate_en` is 1. After that, both outputs and `gate_en` are 0.
- R4: In mode code 3 the source is `pwm_hi`. When the source rises, both outputs are low for `reload_val`×2^`div_sel` clocks, then `drv_hi` goes high. When the source falls, both outputs are low for the same interval, then `drv_lo` goes high.
- R5: Mode code 4 behaves as in R4 but uses `pulse_in` as the source, and `gate_en` follows `pwm_hi` one clock later.
- R6: With `inv_pol` = 1, both outputs are inverted in modes 3 and 4. In that case both are high during the dead interval. `inv_pol` has no effect in the other modes.
- R7: A `reload_val` of 0 inserts no dead time: the outputs switch one clock after the source edge.
- R8: `reload_val` is sampled only when the counter is loaded. Changing it during an interval does not alter that interval.
- R9: The counter decrements once every 2^`div_sel` clocks, counted from the clock in which it was loaded.
- R10: In modes 0 and 1, `tmr_irq` is a one-clock pulse every `reload_val`×2^`div_sel` clocks. A `reload_val` of 0 gives no interrupt. No interrupt occurs in modes 2 to 4.
- R11: While `rst_n` is low, `drv_hi`, `drv_lo`, `gate_en` and `tmr_irq` are 0.
- R12: In modes 3 and 4 with `inv_pol` = 0, `drv_hi` and `drv_lo` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Waveform mode code |
| div_sel | input | DIV_W (2) | Prescaler exponent, 2^div_sel clocks per timer step |
| reload_val | input | CNT_W (16) | Counter load value |
| inv_pol | input | 1 | Invert both outputs in dead-time modes |
| pwm_lo | input | 1 | Low-side PWM level from compare channel |
| pwm_hi | input | 1 | High-side PWM level from compare channel |
| pulse_in | input | 1 | Pulse generator output |
| drv_lo | output | 1 | Low-side gate drive |
| drv_hi | output | 1 | High-side gate drive |
| gate_en | output | 1 | Start request to the pulse generator |
| tmr_irq | output | 1 | Reload-timer interrupt pulse |

## Verification
Pass-through and pulse superimposition are driven with every combination of the PWM and pulse levels. This separates a plain copy from an AND gate and from a swapped pair. Dead-time and timer-gated runs use single edges with several load values and prescaler ratios, and the outputs are checked at every clock of the interval. This exposes an off-by-one in the length, a missing prescaler step, and overlap of the pair. A load value changed in mid-interval, a zero load value and inverted polarity are each tried on their own. The reload timer is measured between two consecutive interrupts, and it is also watched for silence when its value is zero or the mode is one that uses the counter for waveforms.

// File: rtl/dtwg_pkg.sv
package dtwg_pkg;

    typedef enum logic [2:0] {
        MODE_PASS     = 3'd0,
        MODE_CHOP     = 3'd1,
        MODE_TGATE    = 3'd2,
        MODE_DT_PWM   = 3'd3,
        MODE_DT_PULSE = 3'd4
    } dtwg_mode_e;

    function automatic logic is_dead_mode(input logic [2:0] m);
        return (m == MODE_DT_PWM) || (m == MODE_DT_PULSE);
    endfunction

    function automatic logic is_reload_mode(input logic [2:0] m);
        return !((m == MODE_TGATE) || is_dead_mode(m));
    endfunction

endpackage

// File: rtl/dtwg_edge.sv
module dtwg_edge
    import dtwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       pwm_lo,
    input  logic       pwm_hi,
    input  logic       pulse,
    output logic       start,
    output logic       mode_chg
);

    typedef struct packed {
        logic       lo;
        logic       hi;
        logic       pls;
        logic [2:0] mode;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = '{lo: pwm_lo, hi: pwm_hi, pls: pulse, mode: mode};
        mode_chg = (mode != st_q.mode);
        case (mode)
            MODE_TGATE:    start = (pwm_lo & ~st_q.lo) | (pwm_hi & ~st_q.hi);
            MODE_DT_PWM:   start = pwm_hi ^ st_q.hi;
            MODE_DT_PULSE: start = pulse ^ st_q.pls;
            default:       start = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lo: 1'b0, hi: 1'b0, pls: 1'b0, mode: MODE_PASS};
        else        st_q <= st_d;
    end

    // R1: pass-through and chop modes never request a timer start
    p_no_start_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_reload_mode(mode) |-> !start);

endmodule

// File: rtl/dtwg_prescale.sv
module dtwg_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             clr,
    output logic             tick
);

    localparam int PRE_W = (1 << DIV_W) - 1;
    localparam logic [PRE_W:0] ONE = (PRE_W + 1)'(1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = PRE_W'((ONE << div_sel) - ONE);
        tick = (st_q.pre == mask) && !clr;
        st_d = st_q;
        if (clr || (st_q.pre == mask)) st_d.pre = '0;
        else                           st_d.pre = st_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: right after a restart the next step comes only if the ratio is one
    p_restart_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (clr || (tick == (div_sel == '0))));

endmodule

// File: rtl/dtwg_timer.sv
module dtwg_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_mode,
    input  logic             start,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             busy_next,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (start) begin
            st_d.cnt = reload;
        end else if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (reload_mode) begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    st_d.cnt = reload;
                    st_d.irq = (reload != '0);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        busy_next = (st_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R8: a start captures the load value presented in that cycle
    p_start_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.cnt == $past(reload)));

    // R10: interrupts only come from the reload-timer modes
    p_irq_reload_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(reload_mode));

    // R9: without a step, start or clear the count holds
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !clr && !tick) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dtwg_shape.sv
module dtwg_shape
    import dtwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       inv_pol,
    input  logic       pwm_lo,
    input  logic       pwm_hi,
    input  logic       pulse,
    input  logic       busy_next,
    output logic       drv_hi,
    output logic       drv_lo,
    output logic       gate_en
);

    typedef struct packed {
        logic hi;
        logic lo;
        logic gate;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    src;

    always_comb begin
        src  = (mode == MODE_DT_PULSE) ? pulse : pwm_hi;
        st_d = '{hi: pwm_hi, lo: pwm_lo, gate: 1'b0};
        case (mode)
            MODE_CHOP: begin
                st_d = '{hi: pwm_hi & pulse, lo: pwm_lo & pulse, gate: pwm_lo | pwm_hi};
            end
            MODE_TGATE: begin
                st_d = '{hi: pwm_hi & pulse & busy_next,
                         lo: pwm_lo & pulse & busy_next,
                         gate: busy_next};
            end
            MODE_DT_PWM, MODE_DT_PULSE: begin
                if (busy_next) begin
                    st_d.hi = 1'b0;
                    st_d.lo = 1'b0;
                end else begin
                    st_d.hi = src;
                    st_d.lo = ~src;
                end
                if (inv_pol) begin
                    st_d.hi = ~st_d.hi;
                    st_d.lo = ~st_d.lo;
                end
                st_d.gate = (mode == MODE_DT_PULSE) & pwm_hi;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv_hi  = st_q.hi;
    assign drv_lo  = st_q.lo;
    assign gate_en = st_q.gate;

    // R12: the complementary pair never conducts together
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dead_mode($past(mode)) && !$past(inv_pol)) |-> !(drv_hi && drv_lo));

    // R2: in chop mode a driven output implies the pulse was high
    p_chop_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode) == MODE_CHOP) && (drv_hi || drv_lo)) |-> $past(pulse));

endmodule

// File: rtl/dtwg_pair.sv
module dtwg_pair
    import dtwg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             inv_pol,
    input  logic             pwm_lo,
    input  logic             pwm_hi,
    input  logic             pulse_in,
    output logic             drv_lo,
    output logic             drv_hi,
    output logic             gate_en,
    output logic             tmr_irq
);

    logic start, mode_chg, tick, busy_next;

    dtwg_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_sel),
        .pwm_lo   (pwm_lo),
        .pwm_hi   (pwm_hi),
        .pulse    (pulse_in),
        .start    (start),
        .mode_chg (mode_chg)
    );

    dtwg_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .clr     (start | mode_chg),
        .tick    (tick)
    );

    dtwg_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_mode (is_reload_mode(mode_sel)),
        .start       (start),
        .clr         (mode_chg),
        .tick        (tick),
        .reload      (reload_val),
        .busy_next   (busy_next),
        .irq         (tmr_irq)
    );

    dtwg_shape u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_sel),
        .inv_pol   (inv_pol),
        .pwm_lo    (pwm_lo),
        .pwm_hi    (pwm_hi),
        .pulse     (pulse_in),
        .busy_next (busy_next),
        .drv_hi    (drv_hi),
        .drv_lo    (drv_lo),
        .gate_en   (gate_en)
    );

endmodule

// File: tb/dtwg_pair_bench.sv
`timescale 1ns/1ps
module dtwg_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic [1:0]  div_sel = 2'd0;
    logic [15:0] reload_val = 16'd0;
    logic        inv_pol = 1'b0;
    logic        pwm_lo = 1'b0;
    logic        pwm_hi = 1'b0;
    logic        pulse_in = 1'b0;
    logic        drv_lo, drv_hi, gate_en, tmr_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dtwg_pair u_dtwg_pair (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .div_sel(div_sel),
        .reload_val(reload_val), .inv_pol(inv_pol), .pwm_lo(pwm_lo),
        .pwm_hi(pwm_hi), .pulse_in(pulse_in), .drv_lo(drv_lo),
        .drv_hi(drv_hi), .gate_en(gate_en), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_sel = m;
        repeat (3) @(negedge clk);
    endtask

    // drive the dead-time source and follow it through the interval
    task automatic dt_step(input logic use_pulse, input logic val, input int span,
                           input logic inv, input string req);
        @(negedge clk);
        if (use_pulse) pulse_in = val;
        else           pwm_hi = val;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk);
            chk(req, {30'd0, drv_hi, drv_lo}, {30'd0, inv, inv});
        end
        @(negedge clk);
        chk(req, {30'd0, drv_hi, drv_lo}, {30'd0, val ^ inv, ~val ^ inv});
        if (!inv) chk("R12", {31'd0, drv_hi & drv_lo}, 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R11", {28'd0, drv_hi, drv_lo, gate_en, tmr_irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_pass;
        set_mode(3'd0);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            {pwm_hi, pwm_lo} = 2'(v);
            @(negedge clk);
            chk("R1", {29'd0, drv_hi, drv_lo, gate_en}, {29'd0, 2'(v), 1'b0});
        end
        set_mode(3'd6);
        @(negedge clk);
        {pwm_hi, pwm_lo} = 2'b10;
        @(negedge clk);
        chk("R1 code6", {29'd0, drv_hi, drv_lo, gate_en}, {29'd0, 3'b100});
        {pwm_hi, pwm_lo} = 2'b00;
    endtask

    task automatic t_chop;
        set_mode(3'd1);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {pulse_in, pwm_hi, pwm_lo} = 3'(v);
            inv_pol = v[0];
            @(negedge clk);
            chk("R2", {29'd0, drv_hi, drv_lo, gate_en},
                {29'd0, v[1] & v[2], v[0] & v[2], v[0] | v[1]});
        end
        @(negedge clk);
        {pulse_in, pwm_hi, pwm_lo} = 3'b111;
        inv_pol = 1'b1;
        @(negedge clk);
        chk("R6 chop unaffected", {30'd0, drv_hi, drv_lo}, 32'd3);
        {pulse_in, pwm_hi, pwm_lo} = 3'b000;
        inv_pol = 1'b0;
    endtask

    task automatic t_tgate;
        reload_val = 16'd4;
        div_sel = 2'd0;
        set_mode(3'd2);
        @(negedge clk);
        pulse_in = 1'b1;
        pwm_hi = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R3 window", {30'd0, drv_hi, gate_en}, 32'd3);
        end
        @(negedge clk);
        chk("R3 closed", {29'd0, drv_hi, drv_lo, gate_en}, 32'd0);
        @(negedge clk);
        pwm_hi = 1'b0;
        pulse_in = 1'b0;
    endtask

    task automatic t_dt_pwm;
        reload_val = 16'd3;
        div_sel = 2'd0;
        set_mode(3'd3);
        chk("R4 idle", {30'd0, drv_hi, drv_lo}, 32'd1);
        dt_step(1'b0, 1'b1, 3, 1'b0, "R4 rise");
        dt_step(1'b0, 1'b0, 3, 1'b0, "R4 fall");
        div_sel = 2'd2;
        dt_step(1'b0, 1'b1, 12, 1'b0, "R9 div4");
        div_sel = 2'd1;
        dt_step(1'b0, 1'b0, 6, 1'b0, "R9 div2");
        div_sel = 2'd0;
        reload_val = 16'd0;
        dt_step(1'b0, 1'b1, 0, 1'b0, "R7 zero");
        dt_step(1'b0, 1'b0, 0, 1'b0, "R7 zero");
    endtask

    task automatic t_latch;
        reload_val = 16'd5;
        div_sel = 2'd0;
        @(negedge clk);
        pwm_hi = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R8 hold", {30'd0, drv_hi, drv_lo}, 32'd0);
            if (i == 2) reload_val = 16'd1;
        end
        @(negedge clk);
        chk("R8 end", {30'd0, drv_hi, drv_lo}, 32'd2);
        dt_step(1'b0, 1'b0, 1, 1'b0, "R8 new value");
    endtask

    task automatic t_inv;
        reload_val = 16'd2;
        inv_pol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 idle", {30'd0, drv_hi, drv_lo}, 32'd2);
        dt_step(1'b0, 1'b1, 2, 1'b1, "R6 rise");
        dt_step(1'b0, 1'b0, 2, 1'b1, "R6 fall");
        inv_pol = 1'b0;
    endtask

    task automatic t_dt_pulse;
        reload_val = 16'd2;
        set_mode(3'd4);
        @(negedge clk);
        pwm_hi = 1'b1;
        @(negedge clk);
        chk("R5 gate", {31'd0, gate_en}, 32'd1);
        dt_step(1'b1, 1'b1, 2, 1'b0, "R5 rise");
        dt_step(1'b1, 1'b0, 2, 1'b0, "R5 fall");
        @(negedge clk);
        pwm_hi = 1'b0;
        @(negedge clk);
        chk("R5 gate off", {31'd0, gate_en}, 32'd0);
    endtask

    task automatic t_irq;
        int n;
        int seen;
        reload_val = 16'd6;
        div_sel = 2'd1;
        set_mode(3'd0);
        n = 0;
        while (!tmr_irq && n < 100) begin @(negedge clk); n++; end
        chk("R10 first", {31'd0, tmr_irq}, 32'd1);
        n = 0;
        do begin @(negedge clk); n++; end while (!tmr_irq && n < 100);
        chk("R10 period", n, 32'd12);
        reload_val = 16'd0;
        repeat (20) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); seen += tmr_irq; end
        chk("R10 zero", seen, 32'd0);
        reload_val = 16'd2;
        set_mode(3'd3);
        seen = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); seen += tmr_irq; end
        chk("R10 dead mode", seen, 32'd0);
        div_sel = 2'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_pass();
        t_chop();
        t_tgate();
        t_dt_pwm();
        t_latch();
        t_inv();
        t_dt_pulse();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule